// File: doc/BRIEF.md
# Zero-Delay Shared-Multiplier LMS Adaptive Filter

This block is an adaptive FIR filter in direct form with `NTAPS` taps. Its weights follow the least-mean-square rule with no adaptation delay: the error formed for one sample has already changed the weights by the time the next sample is filtered. The block owns the tapped delay line and the weight bank. Its callers supply an input sample, a desired-response sample and a strobe. They get back the filter output and the error.

The block has a single bank of `NTAPS` multipliers, and each sample period is two clock cycles long. A one-bit slot register chooses what the bank does. In the filter slot, each multiplier takes its tap's weight as the second operand, and its product goes to a binary adder tree. The tree output is the full-precision output y, and y is subtracted from the aligned desired value to give the error. In the update slot, each multiplier takes the registered, shifted error as the second operand, and its product goes to that tap's saturating weight adder. The step size is a power of two, so scaling the error needs only an arithmetic shift.

The clock runs at twice the sample rate. A new sample is taken at any edge that closes an update slot. The same edge commits the weights of the previous sample.

Top module: `lms_zd_filter`

## Requirements
- R1: Synchronous reset clears the weights, the delay line, the scaled-error register and both outputs, and it puts the slot register in the update slot.
- R2: `y_out` is the exact sum over k of w(k)·x(n−k). Samples and weights are two's complement with 11 fraction bits, so y carries 22 fraction bits and is 2·DW+log2(NTAPS) bits wide.
- R3: `e_out` is floor((d·2^11 − y) / 2^11), saturated to the range −2048 to +2047.
- R4: The slot register alternates on every clock, and the first edge after reset is an update-slot edge. A strobe is honoured only at update-slot edges. A strobe at a filter-slot edge leaves the delay line and all outputs unchanged.
- R5: `y_out` and `e_out` for a sample load at the first edge after the edge that accepted it. They hold until the next accepted sample reaches that point.
- R6: The scaled error is e arithmetically shifted right by `MU_SHIFT`.
- R7: At the edge that closes the update slot, each weight becomes w(k) + floor(mu·e·x(n−k) / 2^11), saturated to the signed 12-bit range.
- R8: The output for sample n+1 already uses the weights updated from e(n).
- R9: An update slot with no sample pending changes no weight, and without a new sample the delay line and outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe, honoured at update-slot edges |
| x_in | input | DW | Input sample, signed, 11 fraction bits |
| d_in | input | DW | Desired response, signed, 11 fraction bits |
| y_out | output | 2·DW+log2(NTAPS) | Filter output at full precision |
| e_out | output | DW | Truncated, saturated error |

## Verification
The bench counts clock edges from reset release. Because of that count it always knows which slot the next edge closes, and it drives inputs and samples outputs on the falling edge. For a sample taken at edge t, y and e are due after edge t+1. The bench samples them on the following falling edge. The weights from that sample commit at edge t+2, and they can be seen only through the y of the next sample, so the bench compares that y against its own model. Ignored strobes and idle periods are checked by reading the outputs after both edges of an idle pair, and then checking that the next sample still matches a model that neither shifted nor updated.

// File: rtl/lms_zd_pkg.sv
package lms_zd_pkg;

  // Two-cycle sample period: which job the shared multiplier bank does.
  typedef enum logic {
    SLOT_UPDATE = 1'b0,
    SLOT_FILTER = 1'b1
  } slot_e;

endpackage

// File: rtl/lms_tap_line.sv
module lms_tap_line #(
  parameter int NTAPS = 8,
  parameter int DW    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] taps [NTAPS]
);

  // Stage 0 holds x(n); stage k holds x(n-k).
  for (genvar k = 0; k < NTAPS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        taps[k] <= '0;
      end else if (shift_en) begin
        if (k == 0) taps[k] <= din;
        else        taps[k] <= taps[(k == 0) ? 0 : k-1];
      end
    end
  end

endmodule

// File: rtl/lms_shared_mults.sv
module lms_shared_mults #(
  parameter int NTAPS = 8,
  parameter int DW    = 12,
  localparam int PW   = 2*DW
) (
  input  logic                 filter_sel,
  input  logic signed [DW-1:0] taps      [NTAPS],
  input  logic signed [DW-1:0] coef      [NTAPS],
  input  logic signed [DW-1:0] step_err,
  output logic signed [PW-1:0] tree_prod [NTAPS],
  output logic signed [PW-1:0] upd_prod  [NTAPS]
);

  // One multiplier per tap. A 2:1 mux picks the operand; a 1:2 demux
  // steers the product to the adder tree or to the weight adder.
  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    logic signed [DW-1:0] op_b;
    logic signed [PW-1:0] prod;

    always_comb begin
      op_b         = filter_sel ? coef[k] : step_err;
      prod         = taps[k] * op_b;
      tree_prod[k] = filter_sel ? prod : '0;
      upd_prod[k]  = filter_sel ? '0   : prod;
    end
  end

endmodule

// File: rtl/lms_adder_tree.sv
module lms_adder_tree #(
  parameter int NTAPS = 8,
  parameter int IW    = 24,
  localparam int OW   = IW + $clog2(NTAPS)
) (
  input  logic signed [IW-1:0] leaf [NTAPS],
  output logic signed [OW-1:0] sum
);

  logic signed [OW-1:0] part [NTAPS];

  // log2(NTAPS) levels of pairwise addition, each level halving the span.
  always_comb begin
    for (int i = 0; i < NTAPS; i++) begin
      part[i] = OW'(leaf[i]);
    end
    for (int span = NTAPS/2; span >= 1; span = span/2) begin
      for (int i = 0; i < span; i++) begin
        part[i] = part[2*i] + part[2*i+1];
      end
    end
    sum = part[0];
  end

endmodule

// File: rtl/lms_weight_bank.sv
module lms_weight_bank #(
  parameter int NTAPS = 8,
  parameter int DW    = 12,
  localparam int PW   = 2*DW,
  localparam int FRAC = DW-1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit,
  input  logic signed [PW-1:0] upd_prod [NTAPS],
  output logic signed [DW-1:0] w        [NTAPS]
);

  localparam logic signed [PW-1:0] WMAX = (PW'(1) <<< (DW-1)) - 1;
  localparam logic signed [PW-1:0] WMIN = -WMAX - 1;

  // Truncate the increment to weight precision (floor), add, saturate.
  function automatic logic signed [DW-1:0] next_weight(
    input logic signed [DW-1:0] cur,
    input logic signed [PW-1:0] prod
  );
    logic signed [PW-1:0] inc;
    logic signed [PW-1:0] tot;
    inc = prod >>> FRAC;
    tot = PW'(cur) + inc;
    if (tot > WMAX)      tot = WMAX;
    else if (tot < WMIN) tot = WMIN;
    return $signed(tot[DW-1:0]);
  endfunction

  for (genvar k = 0; k < NTAPS; k++) begin : g_w
    always_ff @(posedge clk) begin
      if (rst)         w[k] <= '0;
      else if (commit) w[k] <= next_weight(w[k], upd_prod[k]);
    end
  end

endmodule

// File: rtl/lms_zd_filter.sv
module lms_zd_filter
  import lms_zd_pkg::*;
#(
  parameter int NTAPS    = 8,
  parameter int DW       = 12,
  parameter int MU_SHIFT = 4,
  localparam int ACCW    = 2*DW + $clog2(NTAPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_valid,
  input  logic signed [DW-1:0]   x_in,
  input  logic signed [DW-1:0]   d_in,
  output logic signed [ACCW-1:0] y_out,
  output logic signed [DW-1:0]   e_out
);

  localparam int PW   = 2*DW;
  localparam int FRAC = DW-1;
  localparam int DIFW = ACCW + 1;
  localparam logic signed [DIFW-1:0] EMAX = (DIFW'(1) <<< (DW-1)) - 1;
  localparam logic signed [DIFW-1:0] EMIN = -EMAX - 1;

  // e = floor((d aligned to y's fraction - y) / 2^FRAC), saturated to DW bits.
  function automatic logic signed [DW-1:0] form_error(
    input logic signed [DW-1:0]   d,
    input logic signed [ACCW-1:0] acc
  );
    logic signed [DIFW-1:0] diff;
    logic signed [DIFW-1:0] q;
    diff = (DIFW'(d) <<< FRAC) - DIFW'(acc);
    q    = diff >>> FRAC;
    if (q > EMAX)      q = EMAX;
    else if (q < EMIN) q = EMIN;
    return $signed(q[DW-1:0]);
  endfunction

  // Step size 2^-MU_SHIFT: a shift, no multiplier.
  function automatic logic signed [DW-1:0] scale_step(input logic signed [DW-1:0] e);
    return e >>> MU_SHIFT;
  endfunction

  slot_e                 slot_q;
  logic                  live_q;
  logic signed [DW-1:0]  d_q;
  logic signed [DW-1:0]  mue_q;
  logic signed [ACCW-1:0] y_q;
  logic signed [DW-1:0]  e_q;

  // Named events used by the datapath and the bound checker.
  logic load_ev;
  logic filt_ev;
  logic commit_ev;
  assign load_ev   = (slot_q == SLOT_UPDATE) && smp_valid;
  assign filt_ev   = (slot_q == SLOT_FILTER) && live_q;
  assign commit_ev = (slot_q == SLOT_UPDATE) && live_q;

  logic signed [DW-1:0]   taps      [NTAPS];
  logic signed [DW-1:0]   weights   [NTAPS];
  logic signed [PW-1:0]   tree_prod [NTAPS];
  logic signed [PW-1:0]   upd_prod  [NTAPS];
  logic signed [ACCW-1:0] acc;
  logic signed [DW-1:0]   err_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_UPDATE;
      live_q <= 1'b0;
      d_q    <= '0;
    end else begin
      slot_q <= (slot_q == SLOT_UPDATE) ? SLOT_FILTER : SLOT_UPDATE;
      if (slot_q == SLOT_UPDATE) live_q <= smp_valid;
      if (load_ev)               d_q    <= d_in;
    end
  end

  lms_tap_line #(.NTAPS(NTAPS), .DW(DW)) u_line (
    .clk      (clk),
    .rst      (rst),
    .shift_en (load_ev),
    .din      (x_in),
    .taps     (taps)
  );

  lms_shared_mults #(.NTAPS(NTAPS), .DW(DW)) u_mults (
    .filter_sel (slot_q == SLOT_FILTER),
    .taps       (taps),
    .coef       (weights),
    .step_err   (mue_q),
    .tree_prod  (tree_prod),
    .upd_prod   (upd_prod)
  );

  lms_adder_tree #(.NTAPS(NTAPS), .IW(PW)) u_tree (
    .leaf (tree_prod),
    .sum  (acc)
  );

  assign err_w = form_error(d_q, acc);

  // Scaled-error register breaks the loop between the two slots.
  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      e_q   <= '0;
      mue_q <= '0;
    end else if (filt_ev) begin
      y_q   <= acc;
      e_q   <= err_w;
      mue_q <= scale_step(err_w);
    end
  end

  lms_weight_bank #(.NTAPS(NTAPS), .DW(DW)) u_wbank (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit_ev),
    .upd_prod (upd_prod),
    .w        (weights)
  );

  assign y_out = y_q;
  assign e_out = e_q;

  // Flattened state for the checker.
  logic [NTAPS*DW-1:0] w_flat;
  logic [NTAPS*DW-1:0] tap_flat;
  for (genvar k = 0; k < NTAPS; k++) begin : g_flat
    assign w_flat[k*DW +: DW]   = weights[k];
    assign tap_flat[k*DW +: DW] = taps[k];
  end

endmodule

// File: rtl/lms_zd_filter_chk.sv
module lms_zd_filter_chk #(
  parameter int NTAPS    = 8,
  parameter int DW       = 12,
  parameter int MU_SHIFT = 4,
  localparam int ACCW    = 2*DW + $clog2(NTAPS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   slot,
  input logic                   load_ev,
  input logic                   filt_ev,
  input logic                   commit_ev,
  input logic [NTAPS*DW-1:0]    w_flat,
  input logic [NTAPS*DW-1:0]    tap_flat,
  input logic signed [ACCW-1:0] y_out,
  input logic signed [DW-1:0]   e_out,
  input logic signed [DW-1:0]   mue_q
);

  assert_slot_to_filter_R4: assert property (@(posedge clk) disable iff (rst)
    (slot == 1'b0) |=> (slot == 1'b1));

  assert_slot_to_update_R4: assert property (@(posedge clk) disable iff (rst)
    (slot == 1'b1) |=> (slot == 1'b0));

  assert_line_hold_filter_R4: assert property (@(posedge clk) disable iff (rst)
    (slot == 1'b1) |=> $stable(tap_flat));

  assert_out_latency_R5: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> filt_ev);

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !filt_ev |=> ($stable(y_out) && $stable(e_out)));

  assert_step_scale_R6: assert property (@(posedge clk) disable iff (rst)
    filt_ev |=> (mue_q == (e_out >>> MU_SHIFT)));

  assert_commit_follows_R7: assert property (@(posedge clk) disable iff (rst)
    filt_ev |=> commit_ev);

  assert_weights_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !commit_ev |=> $stable(w_flat));

endmodule

bind lms_zd_filter lms_zd_filter_chk #(
  .NTAPS(NTAPS), .DW(DW), .MU_SHIFT(MU_SHIFT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot      (slot_q),
  .load_ev   (load_ev),
  .filt_ev   (filt_ev),
  .commit_ev (commit_ev),
  .w_flat    (w_flat),
  .tap_flat  (tap_flat),
  .y_out     (y_out),
  .e_out     (e_out),
  .mue_q     (mue_q)
);

// File: tb/lms_zd_filter_bench.sv
`timescale 1ns/1ps
module lms_zd_filter_bench;

  localparam int NTAPS = 8;
  localparam int DW    = 12;
  localparam int MU    = 4;
  localparam int ACCW  = 2*DW + $clog2(NTAPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0]   x_in = '0;
  logic signed [DW-1:0]   d_in = '0;
  logic signed [ACCW-1:0] y_out;
  logic signed [DW-1:0]   e_out;

  always #2 clk = ~clk;

  lms_zd_filter #(.NTAPS(NTAPS), .DW(DW), .MU_SHIFT(MU)) u_lms_zd_filter (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .x_in(x_in), .d_in(d_in), .y_out(y_out), .e_out(e_out)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  longint w_m [NTAPS];
  longint line_m [NTAPS];
  longint last_y, last_e;

  function automatic longint floor_div(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && ((a < 0) != (b < 0))) q = q - 1;
    return q;
  endfunction

  function automatic longint clamp12(input longint v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered on a falling edge before an update-slot edge; returns likewise.
  task automatic send(input longint xv, input longint dv, input string req);
    longint y, e, mue;
    smp_valid = 1'b1; x_in = DW'(xv); d_in = DW'(dv);
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
    for (int k = NTAPS-1; k > 0; k--) line_m[k] = line_m[k-1];
    line_m[0] = xv;
    y = 0;
    for (int k = 0; k < NTAPS; k++) y += w_m[k] * line_m[k];
    e = clamp12(floor_div(dv * 2048 - y, 2048));
    mue = floor_div(e, 1 << MU);
    @(posedge clk); @(negedge clk);
    check({req, " y"}, y_out, y);
    check({req, " e"}, e_out, e);
    for (int k = 0; k < NTAPS; k++)
      w_m[k] = clamp12(w_m[k] + floor_div(mue * line_m[k], 2048));
    last_y = y; last_e = e;
  endtask

  // Two cycles with no accepted sample; optional strobe at the filter-slot edge.
  task automatic idle_pair(input bit stray, input string req);
    smp_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    smp_valid = stray; x_in = 12'sd777; d_in = -12'sd333;
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
    check({req, " y hold"}, y_out, last_y);
    check({req, " e hold"}, e_out, last_e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NTAPS; k++) begin w_m[k] = 0; line_m[k] = 0; end
    last_y = 0; last_e = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 y after reset", y_out, 0);
    check("R1 e after reset", e_out, 0);
  endtask

  task automatic t_first();
    do_reset();
    send(-700, 911, "R3 first");
    check("R2 zero weights give y=0", y_out, 0);
    check("R3 e equals d with zero weights", e_out, 911);
  endtask

  task automatic t_zero_delay();
    do_reset();
    send(1024, 1024, "R8 s0");
    send(1024, 0, "R8 s1");
    check("R8 y uses fresh weight", y_out, 32768);
    check("R8 e from fresh weight", e_out, -16);
  endtask

  task automatic t_train();
    logic [15:0] lfsr = 16'hACE1;
    longint h [NTAPS] = '{300, -500, 800, 1000, -200, 100, 50, -25};
    longint hist [NTAPS];
    longint xv, dv;
    do_reset();
    for (int k = 0; k < NTAPS; k++) hist[k] = 0;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xv = longint'($signed(lfsr[11:0])) / 2;
      for (int k = NTAPS-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = xv;
      dv = 0;
      for (int k = 0; k < NTAPS; k++) dv += h[k] * hist[k];
      dv = clamp12(floor_div(dv, 2048));
      send(xv, dv, "R2 R6 R7 train");
    end
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3; i++) idle_pair(1'b0, "R9 idle");
    send(400, -250, "R9 after idle");
  endtask

  task automatic t_stray();
    idle_pair(1'b1, "R4 stray strobe");
    idle_pair(1'b1, "R4 stray strobe");
    send(-123, 456, "R4 line not shifted");
  endtask

  task automatic t_err_sat();
    do_reset();
    for (int i = 0; i < 40; i++) send(2047, 2047, "R3 pre-neg");
    send(2047, -2048, "R3 neg sat");
    check("R3 e saturates low", e_out, -2048);
    do_reset();
    for (int i = 0; i < 40; i++) send(2047, -2048, "R3 pre-pos");
    send(2047, 2047, "R3 pos sat");
    check("R3 e saturates high", e_out, 2047);
  endtask

  task automatic t_wsat();
    do_reset();
    for (int i = 0; i < 1200; i++) send(64, 2047, "R7 wsat");
    check("R7 weights pinned at max", y_out, NTAPS * 2047 * 64);
    check("R7 residual error", e_out, 1535);
  endtask

  initial begin
    t_reset();
    t_first();
    t_zero_delay();
    t_train();
    t_idle();
    t_stray();
    t_err_sat();
    t_wsat();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule